// File: doc/BRIEF.md
# Product-Term Steering and Sharing Allocator

This block is the configurable OR plane that sits between a product-term array and a bank of macrocells. It takes 80 general product terms and builds 16 sum-of-products outputs. Each output is the OR of the terms that a per-macrocell selection mask picks. Any macrocell may collect any number of terms from 1 to 16, chosen one term at a time. A single term may feed several macrocells at once, but only when all of those macrocells sit in the same group of four (indices 0-3, 4-7, 8-11, 12-15).

The selection masks are held in registers and written one macrocell at a time through a plain configuration port. A write strobe, a macrocell index and an 80-bit mask are presented together, and the write takes effect at the next rising clock edge. The port has no data stream and no handshake. Every write is accepted, so there is no back-pressure. The product terms themselves pass through a single combinational OR level whatever the configuration, so steering and sharing add no delay.

The stored configuration is checked for legality at all times. An illegal configuration raises an error flag, and every macrocell that it affects is forced to 0. The affected macrocells are those with too many or no terms, and those that select a term which is also selected from another group.

Top module: `pta_alloc`

## Requirements
- R1: After reset, macrocell i selects exactly terms 5i to 5i+4 (term bit positions in `pterm`), and `cfg_err` is low.
- R2: With a legal configuration, `mc_sum[i]` is 1 exactly when at least one term selected by macrocell i is 1.
- R3: When `cfg_we` is high at a rising edge, the mask of macrocell `cfg_sel` becomes `cfg_mask` (bit t selects term t). Outputs reflect it right after that edge, and the masks of other macrocells are unchanged.
- R4: Any selection count from 1 to 16 terms is legal for a macrocell, including the extremes 1 and 16.
- R5: A macrocell selecting more than 16 terms raises `cfg_err` and has its output forced to 0.
- R6: A macrocell selecting zero terms raises `cfg_err`, and its output is 0.
- R7: A term selected by several macrocells of the same group is legal and drives all of their outputs.
- R8: A term selected by macrocells in two or more groups raises `cfg_err`, and every macrocell selecting that term is forced to 0. Unaffected macrocells keep working.
- R9: While `cfg_we` is low, the stored configuration is unchanged whatever `cfg_sel` and `cfg_mask` carry.
- R10: The outputs follow `pterm` combinationally, within the same clock cycle and with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, loads the default steering |
| pterm | input | 80 | Product terms, bit t is term t |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Macrocell index written |
| cfg_mask | input | 80 | Term selection mask for the indexed macrocell |
| mc_sum | output | 16 | Sum-of-products per macrocell |
| cfg_err | output | 1 | High while the stored configuration is illegal |

## Verification
A configuration write shows on `mc_sum` and `cfg_err` right after the rising edge that captures it, with no further register in between. The bench drives inputs on falling edges and compares every output against its reference model 1 ns after each rising edge. A change on `pterm` alone is due in the same cycle, so those checks are made a nanosecond after the terms move, well before the next edge. This shows that the path holds no register.

// File: rtl/pta_pkg.sv
package pta_pkg;
  parameter int PTA_TERMS   = 80;
  parameter int PTA_MCELLS  = 16;
  parameter int PTA_GROUP   = 4;
  parameter int PTA_MAX_SEL = 16;
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store #(
  parameter int N_TERMS = pta_pkg::PTA_TERMS,
  parameter int N_MC    = pta_pkg::PTA_MCELLS,
  localparam int SEL_W  = $clog2(N_MC),
  localparam int PER_MC = N_TERMS / N_MC
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [SEL_W-1:0]               sel,
  input  logic [N_TERMS-1:0]             wmask,
  output logic [N_MC-1:0][N_TERMS-1:0]   mask_q
);
  // default: an even, disjoint split of the terms across macrocells
  function automatic logic [N_TERMS-1:0] dflt(input int idx);
    logic [N_TERMS-1:0] m;
    m = '0;
    for (int t = 0; t < N_TERMS; t++)
      if (t >= idx * PER_MC && t < (idx + 1) * PER_MC) m[t] = 1'b1;
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_MC; i++) mask_q[i] <= dflt(i);
    end else if (we) begin
      for (int i = 0; i < N_MC; i++)
        if (sel == SEL_W'(i)) mask_q[i] <= wmask;
    end
  end
endmodule

// File: rtl/pta_legality.sv
module pta_legality #(
  parameter int N_TERMS = pta_pkg::PTA_TERMS,
  parameter int N_MC    = pta_pkg::PTA_MCELLS,
  parameter int GROUP   = pta_pkg::PTA_GROUP,
  parameter int MAX_SEL = pta_pkg::PTA_MAX_SEL,
  localparam int N_GRP  = N_MC / GROUP,
  localparam int CNT_W  = $clog2(N_TERMS + 1)
) (
  input  logic [N_MC-1:0][N_TERMS-1:0] mask,
  output logic [N_MC-1:0]              kill,
  output logic                         err
);
  logic [N_MC-1:0]               count_bad;
  logic [N_GRP-1:0][N_TERMS-1:0] grp_use;
  logic [N_TERMS-1:0]            cross_bad;

  function automatic logic [CNT_W-1:0] popcnt(input logic [N_TERMS-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int t = 0; t < N_TERMS; t++) c = c + CNT_W'(v[t]);
    return c;
  endfunction

  // per-macrocell selection count check
  for (genvar i = 0; i < N_MC; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    assign cnt          = popcnt(mask[i]);
    assign count_bad[i] = (cnt == '0) || (cnt > CNT_W'(MAX_SEL));
  end

  // union of selections within each sharing group
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_comb begin
      grp_use[g] = '0;
      for (int k = 0; k < GROUP; k++) grp_use[g] = grp_use[g] | mask[g*GROUP + k];
    end
  end

  // a term claimed by more than one group is illegal
  always_comb begin
    for (int t = 0; t < N_TERMS; t++) begin
      logic seen, multi;
      seen  = 1'b0;
      multi = 1'b0;
      for (int g = 0; g < N_GRP; g++) begin
        if (grp_use[g][t]) begin
          if (seen) multi = 1'b1;
          seen = 1'b1;
        end
      end
      cross_bad[t] = multi;
    end
  end

  for (genvar i = 0; i < N_MC; i++) begin : g_kill
    assign kill[i] = count_bad[i] | (|(mask[i] & cross_bad));
  end

  assign err = (|count_bad) | (|cross_bad);
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
  parameter int N_TERMS = pta_pkg::PTA_TERMS,
  parameter int N_MC    = pta_pkg::PTA_MCELLS
) (
  input  logic [N_TERMS-1:0]           terms,
  input  logic [N_MC-1:0][N_TERMS-1:0] mask,
  input  logic [N_MC-1:0]              kill,
  output logic [N_MC-1:0]              sums
);
  // one AND-OR level per macrocell, identical for every configuration
  for (genvar i = 0; i < N_MC; i++) begin : g_or
    assign sums[i] = ~kill[i] & (|(terms & mask[i]));
  end
endmodule

// File: rtl/pta_alloc.sv
module pta_alloc #(
  parameter int N_TERMS = pta_pkg::PTA_TERMS,
  parameter int N_MC    = pta_pkg::PTA_MCELLS,
  parameter int GROUP   = pta_pkg::PTA_GROUP,
  parameter int MAX_SEL = pta_pkg::PTA_MAX_SEL,
  localparam int SEL_W  = $clog2(N_MC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TERMS-1:0] pterm,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [N_TERMS-1:0] cfg_mask,
  output logic [N_MC-1:0]    mc_sum,
  output logic               cfg_err
);
  logic [N_MC-1:0][N_TERMS-1:0] mask_q;
  logic [N_MC-1:0]              kill;

  pta_cfg_store #(.N_TERMS(N_TERMS), .N_MC(N_MC)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wmask(cfg_mask), .mask_q(mask_q)
  );

  pta_legality #(.N_TERMS(N_TERMS), .N_MC(N_MC), .GROUP(GROUP),
                 .MAX_SEL(MAX_SEL)) u_legal (
    .mask(mask_q), .kill(kill), .err(cfg_err)
  );

  pta_or_plane #(.N_TERMS(N_TERMS), .N_MC(N_MC)) u_plane (
    .terms(pterm), .mask(mask_q), .kill(kill), .sums(mc_sum)
  );
endmodule

// File: rtl/pta_alloc_chk.sv
module pta_alloc_chk #(
  parameter int N_TERMS = pta_pkg::PTA_TERMS,
  parameter int N_MC    = pta_pkg::PTA_MCELLS,
  parameter int MAX_SEL = pta_pkg::PTA_MAX_SEL,
  localparam int SEL_W  = $clog2(N_MC)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_TERMS-1:0]           pterm,
  input logic                         cfg_we,
  input logic [SEL_W-1:0]             cfg_sel,
  input logic [N_TERMS-1:0]           cfg_mask,
  input logic [N_MC-1:0][N_TERMS-1:0] mask_q,
  input logic [N_MC-1:0]              mc_sum,
  input logic                         cfg_err
);
  p_reset_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cfg_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mask_q));

  for (genvar i = 0; i < N_MC; i++) begin : g_mc
    p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(i)) |=> mask_q[i] == $past(cfg_mask));

    p_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_err && |(mask_q[i] & pterm)) |-> mc_sum[i]);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(mask_q[i] & pterm)) |-> !mc_sum[i]);

    p_over_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mask_q[i]) > MAX_SEL) |-> (!mc_sum[i] && cfg_err));

    p_empty_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[i] == '0) |-> (!mc_sum[i] && cfg_err));
  end
endmodule

bind pta_alloc pta_alloc_chk #(.N_TERMS(N_TERMS), .N_MC(N_MC), .MAX_SEL(MAX_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .pterm(pterm), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_mask(cfg_mask), .mask_q(mask_q), .mc_sum(mc_sum), .cfg_err(cfg_err)
);

// File: tb/tb_pta_alloc.sv
`timescale 1ns/1ps
module tb_pta_alloc;
  localparam int NT = 80;
  localparam int NM = 16;
  localparam int GS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] pterm = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_sel = '0;
  logic [NT-1:0] cfg_mask = '0;
  logic [NM-1:0] mc_sum;
  logic          cfg_err;

  int nchk = 0;
  int nerr = 0;
  logic [NT-1:0] ref_mask [NM];

  always #2.5 clk = ~clk;

  pta_alloc dut (.clk(clk), .rst_n(rst_n), .pterm(pterm), .cfg_we(cfg_we),
                 .cfg_sel(cfg_sel), .cfg_mask(cfg_mask), .mc_sum(mc_sum),
                 .cfg_err(cfg_err));

  function automatic logic [NT-1:0] span(input int lo, input int hi);
    logic [NT-1:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return m;
  endfunction

  // behavioural reference: returns {err, sums}
  function automatic logic [NM:0] model();
    logic [NM-1:0] bad, sums;
    logic [NT-1:0] xbad;
    logic e;
    e = 1'b0; bad = '0; xbad = '0; sums = '0;
    for (int i = 0; i < NM; i++)
      if ($countones(ref_mask[i]) == 0 || $countones(ref_mask[i]) > 16) begin
        bad[i] = 1'b1; e = 1'b1;
      end
    for (int t = 0; t < NT; t++) begin
      int first_grp = -1;
      for (int i = 0; i < NM; i++)
        if (ref_mask[i][t]) begin
          if (first_grp < 0) first_grp = i / GS;
          else if (first_grp != i / GS) xbad[t] = 1'b1;
        end
      if (xbad[t]) e = 1'b1;
    end
    for (int i = 0; i < NM; i++)
      sums[i] = !bad[i] && !(|(ref_mask[i] & xbad)) && (|(ref_mask[i] & pterm));
    return {e, sums};
  endfunction

  task automatic compare(input string tag);
    logic [NM:0] ex;
    ex = model();
    nchk += 2;
    if (mc_sum !== ex[NM-1:0]) begin
      nerr++;
      $display("FAIL %s: mc_sum=%h expected %h", tag, mc_sum, ex[NM-1:0]);
    end
    if (cfg_err !== ex[NM]) begin
      nerr++;
      $display("FAIL %s: cfg_err=%b expected %b", tag, cfg_err, ex[NM]);
    end
  endtask

  task automatic wr(input int sel, input logic [NT-1:0] m, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_mask = m;
    @(posedge clk);
    ref_mask[sel] = m;
    #1 compare(tag);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input logic [NT-1:0] junk, input int sel, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 4'(sel); cfg_mask = junk;
    @(posedge clk);
    #1 compare(tag);
  endtask

  task automatic set_terms(input logic [NT-1:0] v, input string tag);
    @(negedge clk);
    pterm = v;
    #1 compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    nerr++; nchk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NM; i++) ref_mask[i] = span(5*i, 5*i + 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 reset state");
    // R1/R2: one-hot term lands on exactly its default owner
    for (int t = 2; t < NT; t += 11) set_terms(NT'(1) << t, "R1 R2 default steering");
    set_terms('1, "R2 all terms high");
    for (int k = 0; k < 8; k++) set_terms({$urandom, $urandom, $urandom}, "R2 random terms");
    // R10: same-cycle response mid-cycle
    @(posedge clk); #0.5 pterm = NT'(1) << 40; #1 compare("R10 combinational path");
    // R3 R4 R7: macrocell 3 takes 16 terms, sharing 0..4 with macrocell 0
    wr(3, span(0, 15), "R3 R4 R7 sixteen shared in group");
    set_terms(NT'(1), "R7 shared term drives two outputs");
    set_terms(NT'(1) << 15, "R3 other masks kept");
    // R4: a single term
    wr(7, NT'(1) << 36, "R4 single term");
    set_terms(NT'(1) << 36, "R4 single term hit");
    set_terms(NT'(1) << 35, "R4 dropped term");
    // R9: writes masked off
    set_terms('1, "R9 setup");
    idle('0, 5, "R9 no write with zero mask");
    idle('1, 9, "R9 no write with full mask");
    set_terms({$urandom, $urandom, $urandom}, "R9 config intact");
    // R5: seventeen terms
    set_terms('1, "R5 setup");
    wr(5, span(20, 36), "R5 over limit");
    wr(5, span(25, 29), "R5 restore");
    // R6: zero terms
    wr(9, '0, "R6 empty macrocell");
    wr(9, span(45, 49), "R6 restore");
    // R8: cross-group sharing of term 0 by macrocell 12
    wr(12, span(60, 64) | NT'(1), "R8 cross group share");
    set_terms({$urandom, $urandom, $urandom} | NT'(1), "R8 affected forced low");
    wr(12, span(60, 64), "R8 cleared");
    for (int k = 0; k < 6; k++) set_terms({$urandom, $urandom, $urandom}, "R2 final random");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule